// File: doc/BRIEF.md
# Self-Timed Page Programming Controller

This controller performs the programming step of a small page-organised nonvolatile store. A bus front-end sends it a one-cycle request when the stop condition that ends a write transfer arrives. The request carries a page number, a full page buffer of bytes and one enable bit per byte. The controller first checks the global write-protect pin and the protection bit of that page. If either one blocks the change, the request is dropped and the block stays idle. Otherwise the controller runs two timed phases. The erase phase sets every selected byte to 0xFF. The write phase then loads the selected bytes from the buffer. Bytes whose enable bit is clear keep their old contents.

A second request type updates the per-page protection bits. It uses its own, shorter timer. While either operation runs, the busy output is high. The front-end uses busy to refuse new commands, which is the behaviour seen in acknowledge polling. The phase lengths are parameters counted in clock cycles, so the millisecond limits of real cells map onto cycle counts. The storage array is built from registers and can be read combinationally, so the surrounding logic and the bench can observe its contents.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: A data request made while idle, with `wp_pin` low and the page's protection bit at 1, raises `busy` in the next cycle. `busy` then stays high for exactly ERASE_CYC+WRITE_CYC cycles.
- R2: From the first busy cycle until `busy` falls, every selected byte of the page reads 0xFF.
- R3: Byte i of page p sits at address p*PAGE_BYTES+i. Its enable is `req_mask[i]` and its data is `req_data[8*i+7:8*i]`. In the cycle in which `busy` falls, every enabled byte reads its buffer value.
- R4: Bytes whose mask bit is 0, and all bytes of other pages, are never changed by a request. While the block is idle, array contents do not change.
- R5: While `wp_pin` is 1, both data requests and protection requests are dropped. `busy` stays low and neither the array nor the protection bits change.
- R6: A data request to a page whose protection bit is 0 is dropped without raising `busy` and leaves the array unchanged. A request made in the very next cycle is accepted.
- R7: A protection request made while idle with `wp_pin` low keeps `busy` high for exactly PBIT_CYC cycles. When `busy` falls, the page's bit equals `pbit_value`, where 1 means writable and 0 means protected. Page data is left untouched.
- R8: Requests of either type that arrive while `busy` is high are ignored.
- R9: If a data request and a protection request arrive in the same cycle, only the data request is considered. The protection request is dropped.
- R10: After reset, `busy` is 0, every byte reads 0xFF and every protection bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin | input | 1 | Global write protect, 1 blocks all changes |
| req_valid | input | 1 | One-cycle data program request (stop condition seen) |
| req_page | input | PAGE_AW | Page to program |
| req_data | input | PAGE_BYTES*8 | Page buffer, byte i in bits 8i+7..8i |
| req_mask | input | PAGE_BYTES | Per-byte enable of the buffer |
| pbit_req | input | 1 | One-cycle protection bit update request |
| pbit_page | input | PAGE_AW | Page whose protection bit is updated |
| pbit_value | input | 1 | New bit value, 1 writable, 0 protected |
| rd_addr | input | ADDR_AW | Byte address for reading the array |
| rd_data | output | 8 | Array byte at rd_addr |
| rd_pbit_page | input | PAGE_AW | Page whose protection bit is read |
| rd_pbit | output | 1 | Protection bit of rd_pbit_page |
| busy | output | 1 | An erase/write or protection cycle is running |

## Verification
The properties assume that request pulses last one cycle and that `rd_addr` changes only when the bench chooses. The hold property compares the byte read across two idle cycles only when the address is steady. The bench drives every request and read address on the falling edge and pulses each request for exactly one cycle. It issues the requests that must be ignored only in cycles whose outcome it has already decided: in a busy cycle, with the pin high, or to a protected page. Its model of the array and of the protection bits changes only when a request is due to be accepted.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_WRITE = 2'd2,
        ST_PBIT  = 2'd3
    } prog_state_e;
endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/page_array.sv
module page_array #(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 16,
    localparam int PAGE_AW   = $clog2(PAGES),
    localparam int ADDR_AW   = $clog2(PAGES * PAGE_BYTES),
    localparam int BUF_W     = PAGE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [PAGE_AW-1:0]    page,
    input  logic [PAGE_BYTES-1:0] mask,
    input  logic [BUF_W-1:0]      wdata,
    input  logic [ADDR_AW-1:0]    rd_addr,
    output logic [7:0]            rd_data
);
    localparam int NBYTES = PAGES * PAGE_BYTES;

    logic [7:0] mem_q [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_cell
        localparam int PG = g / PAGE_BYTES;
        localparam int BI = g % PAGE_BYTES;
        logic sel;
        assign sel = we && (page == PAGE_AW'(PG)) && mask[BI];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mem_q[g] <= 8'hFF;
            else if (sel) mem_q[g] <= wdata[8*BI +: 8];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/prot_store.sv
module prot_store #(
    parameter int PAGES   = 8,
    localparam int PAGE_AW = $clog2(PAGES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PAGE_AW-1:0] wr_page,
    input  logic               wr_val,
    input  logic [PAGE_AW-1:0] page_a,
    output logic               bit_a,
    input  logic [PAGE_AW-1:0] page_b,
    output logic               bit_b
);
    logic [PAGES-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bits_q <= '1;
        else if (we) bits_q[wr_page] <= wr_val;
    end

    assign bit_a = bits_q[page_a];
    assign bit_b = bits_q[page_b];
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
    import eeprom_prog_pkg::*;
#(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 16,
    parameter int ERASE_CYC  = 16,
    parameter int WRITE_CYC  = 24,
    parameter int PBIT_CYC   = 12,
    localparam int PAGE_AW   = $clog2(PAGES),
    localparam int ADDR_AW   = $clog2(PAGES * PAGE_BYTES),
    localparam int BUF_W     = PAGE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wp_pin,
    input  logic                  req_valid,
    input  logic [PAGE_AW-1:0]    req_page,
    input  logic [BUF_W-1:0]      req_data,
    input  logic [PAGE_BYTES-1:0] req_mask,
    input  logic                  pbit_req,
    input  logic [PAGE_AW-1:0]    pbit_page,
    input  logic                  pbit_value,
    input  logic [ADDR_AW-1:0]    rd_addr,
    output logic [7:0]            rd_data,
    input  logic [PAGE_AW-1:0]    rd_pbit_page,
    output logic                  rd_pbit,
    output logic                  busy
);
    localparam int MAX_EW  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int MAX_CYC = (MAX_EW > PBIT_CYC) ? MAX_EW : PBIT_CYC;
    localparam int TIMER_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        prog_state_e           state;
        logic [PAGE_AW-1:0]    page;
        logic [BUF_W-1:0]      data;
        logic [PAGE_BYTES-1:0] mask;
        logic                  pbit_val;
    } ctl_t;

    ctl_t cur_d, cur_q;

    logic                  tmr_load;
    logic [TIMER_W-1:0]    tmr_val;
    logic                  tmr_done;
    logic                  arr_we;
    logic [PAGE_AW-1:0]    arr_page;
    logic [PAGE_BYTES-1:0] arr_mask;
    logic [BUF_W-1:0]      arr_wdata;
    logic                  pb_we;
    logic                  req_page_open;

    // Next-state logic: gate the request, then sequence erase, write and
    // protection phases off the shared timer.
    always_comb begin
        cur_d     = cur_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        arr_we    = 1'b0;
        arr_page  = cur_q.page;
        arr_mask  = cur_q.mask;
        arr_wdata = cur_q.data;
        pb_we     = 1'b0;

        unique case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!wp_pin && req_page_open) begin
                        cur_d.state = ST_ERASE;
                        cur_d.page  = req_page;
                        cur_d.data  = req_data;
                        cur_d.mask  = req_mask;
                        tmr_load    = 1'b1;
                        tmr_val     = TIMER_W'(ERASE_CYC - 1);
                        // erase the selected bytes as the phase begins
                        arr_we      = 1'b1;
                        arr_page    = req_page;
                        arr_mask    = req_mask;
                        arr_wdata   = '1;
                    end
                end else if (pbit_req && !wp_pin) begin
                    cur_d.state    = ST_PBIT;
                    cur_d.page     = pbit_page;
                    cur_d.pbit_val = pbit_value;
                    tmr_load       = 1'b1;
                    tmr_val        = TIMER_W'(PBIT_CYC - 1);
                end
            end
            ST_ERASE: begin
                if (tmr_done) begin
                    cur_d.state = ST_WRITE;
                    tmr_load    = 1'b1;
                    tmr_val     = TIMER_W'(WRITE_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    cur_d.state = ST_IDLE;
                    arr_we      = 1'b1;
                end
            end
            ST_PBIT: begin
                if (tmr_done) begin
                    cur_d.state = ST_IDLE;
                    pb_we       = 1'b1;
                end
            end
            default: cur_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state    <= ST_IDLE;
            cur_q.page     <= '0;
            cur_q.data     <= '0;
            cur_q.mask     <= '0;
            cur_q.pbit_val <= 1'b1;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign busy = (cur_q.state != ST_IDLE);

    prog_timer #(.W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    page_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .page    (arr_page),
        .mask    (arr_mask),
        .wdata   (arr_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    prot_store #(.PAGES(PAGES)) u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (pb_we),
        .wr_page (cur_q.page),
        .wr_val  (cur_q.pbit_val),
        .page_a  (req_page),
        .bit_a   (req_page_open),
        .page_b  (rd_pbit_page),
        .bit_b   (rd_pbit)
    );
endmodule

// File: rtl/eeprom_prog_checker.sv
module eeprom_prog_checker #(
    parameter int ERASE_CYC = 16,
    parameter int WRITE_CYC = 24,
    parameter int PBIT_CYC  = 12,
    parameter int ADDR_AW   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wp_pin,
    input logic               req_valid,
    input logic               pbit_req,
    input logic [ADDR_AW-1:0] rd_addr,
    input logic [7:0]         rd_data,
    input logic               busy
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= '0;
    end

    // R1 and R7: a busy run lasts one of the two programmed durations
    assert_run_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(ERASE_CYC + WRITE_CYC) || run_len == 32'(PBIT_CYC)));

    assert_wp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wp_pin) |=> !busy);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(rd_addr)) |-> $stable(rd_data));

    assert_busy_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid || pbit_req));
endmodule

bind eeprom_prog_ctrl eeprom_prog_checker #(
    .ERASE_CYC (ERASE_CYC),
    .WRITE_CYC (WRITE_CYC),
    .PBIT_CYC  (PBIT_CYC),
    .ADDR_AW   (ADDR_AW)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_pin    (wp_pin),
    .req_valid (req_valid),
    .pbit_req  (pbit_req),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (busy)
);

// File: tb/eeprom_prog_ctrl_bench.sv
`timescale 1ns/100ps
module eeprom_prog_ctrl_bench;
    localparam int PAGES = 4;
    localparam int PB    = 16;
    localparam int EC    = 3;
    localparam int WC    = 5;
    localparam int PC    = 2;
    localparam int PAW   = $clog2(PAGES);
    localparam int AAW   = $clog2(PAGES * PB);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wp_pin = 1'b0;
    logic           req_valid = 1'b0;
    logic [PAW-1:0] req_page = '0;
    logic [PB*8-1:0] req_data = '0;
    logic [PB-1:0]  req_mask = '0;
    logic           pbit_req = 1'b0;
    logic [PAW-1:0] pbit_page = '0;
    logic           pbit_value = 1'b1;
    logic [AAW-1:0] rd_addr = '0;
    logic [7:0]     rd_data;
    logic [PAW-1:0] rd_pbit_page = '0;
    logic           rd_pbit;
    logic           busy;

    logic [7:0] model_mem [PAGES*PB];
    logic       model_pb  [PAGES];
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    eeprom_prog_ctrl #(
        .PAGES(PAGES), .PAGE_BYTES(PB),
        .ERASE_CYC(EC), .WRITE_CYC(WC), .PBIT_CYC(PC)
    ) u_eeprom_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
        .req_valid(req_valid), .req_page(req_page), .req_data(req_data),
        .req_mask(req_mask), .pbit_req(pbit_req), .pbit_page(pbit_page),
        .pbit_value(pbit_value), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_pbit_page(rd_pbit_page), .rd_pbit(rd_pbit), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_byte(input int a, output logic [7:0] v);
        rd_addr = AAW'(a);
        #0.5;
        v = rd_data;
    endtask

    task automatic read_pbit(input int p, output logic v);
        rd_pbit_page = PAW'(p);
        #0.5;
        v = rd_pbit;
    endtask

    task automatic verify_page(input int p, input string tag);
        logic [7:0] v;
        for (int i = 0; i < PB; i++) begin
            read_byte(p*PB + i, v);
            check(v == model_mem[p*PB + i], tag, v, model_mem[p*PB + i]);
        end
    endtask

    // measure busy run starting at the current (first busy) falling edge
    task automatic busy_run(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
    endtask

    task automatic set_buf(input int seed, input logic [PB-1:0] m);
        for (int i = 0; i < PB; i++)
            req_data[8*i +: 8] = 8'((seed * 7 + i * 13 + 1) & 255);
        req_mask = m;
    endtask

    // data request, then check outcome; accept says whether it must start
    task automatic do_prog(input int p, input logic [PB-1:0] m, input int seed,
                           input bit accept, input string tag);
        logic [7:0] v;
        int n;
        @(negedge clk);
        req_page = PAW'(p);
        set_buf(seed, m);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (accept) begin
            check(busy == 1'b1, "R1 busy rises", busy, 1);
            for (int i = 0; i < PB; i++) begin
                if (m[i]) begin
                    read_byte(p*PB + i, v);
                    check(v == 8'hFF, "R2 erased byte", v, 8'hFF);
                    break;
                end
            end
            busy_run(n);
            check(n == EC + WC, "R1 busy length", n, EC + WC);
            for (int i = 0; i < PB; i++)
                if (m[i]) model_mem[p*PB + i] = req_data[8*i +: 8];
            verify_page(p, "R3/R4 page contents");
        end else begin
            check(busy == 1'b0, "R5/R6 busy stays low", busy, 0);
            verify_page(p, "R5/R6 page unchanged");
        end
    endtask

    task automatic do_pbit(input int p, input logic val, input bit accept, input string tag);
        logic v;
        int n;
        @(negedge clk);
        pbit_page = PAW'(p);
        pbit_value = val;
        pbit_req = 1'b1;
        @(negedge clk);
        pbit_req = 1'b0;
        if (accept) begin
            check(busy == 1'b1, "R7 busy rises", busy, 1);
            busy_run(n);
            check(n == PC, "R7 busy length", n, PC);
            model_pb[p] = val;
        end else begin
            check(busy == 1'b0, tag, busy, 0);
        end
        read_pbit(p, v);
        check(v == model_pb[p], "R7 protection bit", v, model_pb[p]);
        verify_page(p, "R7 data untouched");
    endtask

    initial begin
        #200000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic pv;
        int n;
        logic [PB-1:0] masks [6];
        masks[0] = 16'hFFFF; masks[1] = 16'h0001; masks[2] = 16'h8000;
        masks[3] = 16'hAAAA; masks[4] = 16'h5555; masks[5] = 16'h0000;

        for (int i = 0; i < PAGES*PB; i++) model_mem[i] = 8'hFF;
        for (int p = 0; p < PAGES; p++) model_pb[p] = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(busy == 1'b0, "R10 busy after reset", busy, 0);
        for (int i = 0; i < PAGES*PB; i++) begin
            read_byte(i, v);
            check(v == 8'hFF, "R10 erased array", v, 8'hFF);
        end
        for (int p = 0; p < PAGES; p++) begin
            read_pbit(p, pv);
            check(pv == 1'b1, "R10 protection bit", pv, 1);
        end

        // sweep every page with every mask pattern (R1 R2 R3 R4)
        for (int p = 0; p < PAGES; p++)
            for (int k = 0; k < 6; k++)
                do_prog(p, masks[k], p * 6 + k, 1'b1, "sweep");

        // R8: requests during busy are ignored
        @(negedge clk);
        req_page = 0; set_buf(99, 16'hFFFF); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < PB; i++) model_mem[i] = req_data[8*i +: 8];
        @(negedge clk);
        req_page = 1; set_buf(55, 16'hFFFF); req_valid = 1'b1;
        pbit_req = 1'b1; pbit_page = 1; pbit_value = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; pbit_req = 1'b0;
        busy_run(n);
        check(n == EC + WC - 2, "R8 single busy run", n, EC + WC - 2);
        verify_page(0, "R8 first request written");
        verify_page(1, "R8 page unchanged");
        read_pbit(1, pv);
        check(pv == 1'b1, "R8 protection bit unchanged", pv, 1);

        // R7 protect page 2, then R6 suppressed write and immediate follow-up
        do_pbit(2, 1'b0, 1'b1, "R7");
        do_prog(2, 16'hFFFF, 200, 1'b0, "R6");
        do_pbit(2, 1'b1, 1'b1, "R6 next request accepted");
        do_prog(2, 16'h0FF0, 201, 1'b1, "R6 after unprotect");

        // R5 write-protect pin blocks everything
        wp_pin = 1'b1;
        do_prog(3, 16'hFFFF, 300, 1'b0, "R5");
        do_pbit(3, 1'b0, 1'b0, "R5 protection request dropped");
        wp_pin = 1'b0;

        // R9 simultaneous requests: data wins
        @(negedge clk);
        req_page = 3; set_buf(400, 16'h00FF); req_valid = 1'b1;
        pbit_req = 1'b1; pbit_page = 3; pbit_value = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; pbit_req = 1'b0;
        for (int i = 0; i < PB; i++)
            if (req_mask[i]) model_mem[3*PB + i] = req_data[8*i +: 8];
        busy_run(n);
        check(n == EC + WC, "R9 data request length", n, EC + WC);
        read_pbit(3, pv);
        check(pv == 1'b1, "R9 protection request dropped", pv, 1);
        verify_page(3, "R9 page written");

        // R4 no other page disturbed over the whole run
        for (int p = 0; p < PAGES; p++) verify_page(p, "R4 final array");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule